// File: doc/BRIEF.md
# Wait-State Memory Bus Master

This block turns single read or write requests from a processor-side port into transfers on a slow parallel memory bus. The bus has an address output, a data bus split into an input, an output and an output enable, and two active-low strobes, one for reads and one for writes. Only one transfer is in flight at a time. The requester offers a request with a valid/ready handshake. The block accepts it when ready is high, and later answers with a done pulse that lasts one cycle. The captured read data comes out with that pulse.

Each transfer runs in four phases. In the setup phase the address is driven while both strobes stay high. In the strobe phase one strobe is low. The wait states come from a programmable minimum count and from a memory ready input, and the strobe stays low until both have been met. In the hold phase the strobe is high again and the address and write data are still driven. Last comes the completion cycle. A write turns on the data output enable together with its strobe. A read samples the data input in the last cycle of its strobe.

Top module: `memwait_master`

## Requirements
- R1: During and directly after reset, `mem_rd_n` and `mem_wr_n` are high, `mem_dout_en` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle of the matching done pulse.
- R3: In the first cycle after acceptance, `mem_addr` carries the request address and both strobes are high (setup cycle).
- R4: The strobe stays low for max(MIN_WAIT, D) + 1 cycles, where D is the number of strobe-low cycles before `mem_ready` is seen high. The strobe rises only after an edge at which `mem_ready` was high.
- R5: A read (`req_write` = 0) drives only `mem_rd_n` low. The value on `mem_din` in its last strobe-low cycle appears on `rsp_rdata` together with `rsp_done`.
- R6: A write (`req_write` = 1) drives only `mem_wr_n` low. `mem_dout_en` rises in the same cycle that `mem_wr_n` falls, and `mem_dout` equals the request's write data while the strobe is low.
- R7: `mem_addr` stays equal to the request address, and `mem_dout` stays equal to the write data, from the setup cycle through the hold cycle that follows the strobe's rise and up to the done cycle.
- R8: `rsp_done` is high for exactly one cycle, two cycles after the strobe rises, and `req_ready` is high again in that same cycle.
- R9: The two strobes are never low at the same time. `mem_dout_en` is never high during a read.
- R10: A request offered while `req_ready` is low is ignored. It changes neither the bus address nor the strobes, and it starts no later transfer.
- R11: `rsp_rdata` changes only when a read completes. A write leaves the last read value in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last captured read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_dout_en | output | 1 | Output enable for `mem_dout` |
| mem_din | input | DATA_W | Data returned by memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_ready | input | 1 | Memory ready, active high |

## Verification
The bench builds the block with MIN_WAIT = 2, ADDR_W = 12 and DATA_W = 8. With a minimum of two wait states, the bench can tell the case where the minimum count ends the strobe (ready at once or after one cycle) from the case where a late ready ends it (delays of four and five cycles). A one-cycle error in either path then changes the measured strobe length. The 8-bit data width keeps the small memory model and its expected-value shadow easy to follow across write-then-read sequences.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } bus_phase_e;
endpackage

// File: rtl/memwait_req_latch.sv
module memwait_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              finish,
  output logic              req_ready,
  output logic              accept,
  output logic              hold_write,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_wdata
);
  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b1;
      hold_write <= 1'b0;
      hold_addr  <= '0;
      hold_wdata <= '0;
    end else if (accept) begin
      req_ready  <= 1'b0;
      hold_write <= req_write;
      hold_addr  <= req_addr;
      hold_wdata <= req_wdata;
    end else if (finish) begin
      req_ready  <= 1'b1;
    end
  end

  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> ($stable(hold_addr) && $stable(hold_wdata) && $stable(hold_write)));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/memwait_wait_timer.sv
module memwait_wait_timer #(
  parameter int MIN_WAIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic min_met
);
  generate
    if (MIN_WAIT == 0) begin : g_nowait
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, clear, run};
      assign min_met = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(MIN_WAIT + 1);
      localparam logic [CW-1:0] LIMIT = CW'(MIN_WAIT);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          cnt <= '0;
        end else if (run && (cnt < LIMIT)) begin
          cnt <= cnt + 1'b1;
        end
      end

      assign min_met = (cnt >= LIMIT);

      // R4
      cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/memwait_bus_seq.sv
module memwait_bus_seq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              hold_write,
  input  logic              min_met,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_din,
  output logic              tmr_clear,
  output logic              tmr_run,
  output logic              finish,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_dout_en,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  import memwait_pkg::*;

  bus_phase_e phase;
  logic       leave_strobe;

  assign leave_strobe = (phase == PH_STROBE) && min_met && mem_ready;
  assign tmr_clear    = (phase == PH_SETUP);
  assign tmr_run      = (phase == PH_STROBE);
  assign finish       = (phase == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      mem_rd_n    <= 1'b1;
      mem_wr_n    <= 1'b1;
      mem_dout_en <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) phase <= PH_SETUP;
        end
        PH_SETUP: begin
          phase       <= PH_STROBE;
          mem_rd_n    <= hold_write;
          mem_wr_n    <= !hold_write;
          mem_dout_en <= hold_write;
        end
        PH_STROBE: begin
          if (leave_strobe) begin
            phase    <= PH_HOLD;
            mem_rd_n <= 1'b1;
            mem_wr_n <= 1'b1;
            if (!hold_write) rsp_rdata <= mem_din;
          end
        end
        PH_HOLD: begin
          phase       <= PH_IDLE;
          mem_dout_en <= 1'b0;
          rsp_done    <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_wr_n));

  // R9
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dout_en |-> mem_rd_n);

  // R4
  ready_before_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_rd_n) || $rose(mem_wr_n)) |-> $past(mem_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R11
  rdata_write_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && hold_write) |=> $stable(rsp_rdata));
endmodule

// File: rtl/memwait_master.sv
module memwait_master #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int MIN_WAIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  input  logic              mem_ready
);
  logic accept;
  logic hold_write;
  logic finish;
  logic tmr_clear;
  logic tmr_run;
  logic min_met;

  memwait_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .finish     (finish),
    .req_ready  (req_ready),
    .accept     (accept),
    .hold_write (hold_write),
    .hold_addr  (mem_addr),
    .hold_wdata (mem_dout)
  );

  memwait_wait_timer #(.MIN_WAIT(MIN_WAIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .min_met (min_met)
  );

  memwait_bus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .hold_write  (hold_write),
    .min_met     (min_met),
    .mem_ready   (mem_ready),
    .mem_din     (mem_din),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .finish      (finish),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_dout_en (mem_dout_en),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata)
  );

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dout)));
endmodule

// File: tb/tb_memwait_master.sv
module tb_memwait_master;
  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int MW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_dout_en;
  logic [DW-1:0] mem_din;
  logic          mem_rd_n;
  logic          mem_wr_n;
  logic          mem_ready;

  int            checks = 0;
  int            fails  = 0;
  int            rdy_delay = 0;
  int            lo_cnt = 0;
  logic [DW-1:0] mem_model [16];
  logic [DW-1:0] shadow    [16];
  logic [DW-1:0] last_rd = '0;

  always #4 clk = ~clk;

  memwait_master #(.ADDR_W(AW), .DATA_W(DW), .MIN_WAIT(MW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_ready(mem_ready)
  );

  // slow memory model
  assign mem_ready = (!mem_rd_n || !mem_wr_n) && (lo_cnt >= rdy_delay);
  assign mem_din   = mem_model[mem_addr[3:0]];

  always @(posedge clk) begin
    lo_cnt <= (!mem_rd_n || !mem_wr_n) ? lo_cnt + 1 : 0;
    if (!mem_wr_n && mem_ready) mem_model[mem_addr[3:0]] <= mem_dout;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int dly, input bit intrude);
    int  low = 0;
    bit  addr_ok = 1, dout_ok = 1, excl_ok = 1, en_ok = 1, seen = 0, side_ok = 1;
    int  exp_low;
    exp_low = ((dly > MW) ? dly : MW) + 1;
    rdy_delay = dly;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (intrude) begin
      req_write = ~wr; req_addr = a ^ 12'h5A5; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    chk(mem_addr == a && mem_rd_n && mem_wr_n, "R3", "setup addr/strobes", mem_addr, a);
    chk(!req_ready, "R2", "ready low after accept", req_ready, 0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rsp_done) begin seen = 1; break; end
      if (!mem_rd_n && !mem_wr_n) excl_ok = 0;
      if (!mem_rd_n || !mem_wr_n) low++;
      if (wr ? !mem_rd_n : !mem_wr_n) side_ok = 0;
      if (mem_addr != a) addr_ok = 0;
      if (wr && !mem_wr_n && (!mem_dout_en || mem_dout != d)) dout_ok = 0;
      if (wr && low > 0 && mem_dout != d) dout_ok = 0;
      if (!wr && mem_dout_en) en_ok = 0;
      if (intrude && low > 0 && mem_rd_n && mem_wr_n) req_valid = 1'b0;
    end
    chk(seen, "R8", "done pulse seen", seen, 1);
    chk(req_ready, "R8", "ready back with done", req_ready, 1);
    chk(addr_ok && mem_addr == a, "R7", "address held", mem_addr, a);
    chk(excl_ok, "R9", "strobes exclusive", excl_ok, 1);
    chk(low == exp_low, wr ? "R4" : "R4", "strobe low cycles", low, exp_low);
    if (wr) begin
      chk(side_ok, "R6", "only write strobe used", side_ok, 1);
      chk(dout_ok, "R6", "write data driven/held (R7)", dout_ok, 1);
      chk(rsp_rdata == last_rd, "R11", "rdata kept on write", rsp_rdata, last_rd);
      shadow[a[3:0]] = d;
    end else begin
      chk(side_ok, "R5", "only read strobe used", side_ok, 1);
      chk(en_ok, "R9", "no output enable on read", en_ok, 1);
      chk(rsp_rdata == shadow[a[3:0]], "R5", "read data", rsp_rdata, shadow[a[3:0]]);
      last_rd = shadow[a[3:0]];
    end
    @(negedge clk);
    chk(!rsp_done, "R8", "done lasts one cycle", rsp_done, 0);
    chk(!mem_dout_en, "R9", "output enable off after transfer", mem_dout_en, 0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(mem_rd_n && mem_wr_n && mem_addr == a && !rsp_done, "R10",
          "busy request ignored", mem_addr, a);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_model[i] = DW'(i * 17 + 3);
      shadow[i]    = DW'(i * 17 + 3);
    end
    repeat (3) @(negedge clk);
    chk(mem_rd_n && mem_wr_n && !mem_dout_en && !rsp_done, "R1", "strobes in reset",
        {mem_rd_n, mem_wr_n, mem_dout_en, rsp_done}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_rd_n && mem_wr_n && !mem_dout_en, "R1", "idle after reset",
        {req_ready, mem_rd_n, mem_wr_n, mem_dout_en}, 4'b1110);
    xfer(1'b0, 12'h003, 8'h00, 0, 1'b0);   // read, minimum wait rules
    xfer(1'b0, 12'h107, 8'h00, 5, 1'b0);   // read, late ready
    xfer(1'b1, 12'h20A, 8'hC3, 0, 1'b0);   // write, minimum wait rules
    xfer(1'b1, 12'h30C, 8'h5E, 4, 1'b0);   // write, late ready
    xfer(1'b0, 12'h00A, 8'h00, 1, 1'b0);   // read back written value
    xfer(1'b0, 12'h40C, 8'h00, 3, 1'b1);   // busy request ignored
    xfer(1'b1, 12'h001, 8'h99, 2, 1'b0);   // back-to-back
    xfer(1'b0, 12'h001, 8'h00, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule